// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block gives a processor three 16-bit down-counters behind a byte-wide register window of four locations. Software writes a control word that names a channel and sets how that channel's count bytes are reached. It then writes the reload value one byte at a time through the channel's own count location. A channel starts counting only when the high byte of its reload value arrives. From then on it steps down once for each pulse on the timebase enable, and it reloads itself each time it passes terminal count.

Channel 0 drives the interrupt line. Each terminal count of channel 0 adds one to a small pending counter. The interrupt stays asserted for as long as that counter is not zero, whatever operating mode was programmed. Each pulse on the acknowledge input retires one pending event. Channels 1 and 2 count and can be read back, but they drive no output. Decimal counting is not supported: a control word that asks for it raises an error flag and changes nothing about how the channels count.

Top module: `ivt_timer3`

## Requirements
- R1: Address 3 is the control location and addresses 0, 1 and 2 are the count locations of channels 0, 1 and 2. A read of address 3 returns the last control word written, which is 0x04 after reset.
- R2: Control word layout: bits 7:6 name the channel, bits 5:4 give the byte-access field, bits 3:1 give the operating mode and bit 0 asks for decimal counting. A channel field of 3 acts on channel 0.
- R3: The access field of the addressed channel sets which byte a count access reaches: 01 means the low byte only and 10 means the high byte only. Under 00, which is the value after reset, count writes change nothing and count reads return 0x00.
- R4: Under access field 11, the first count access after that channel's control word reaches the low byte. Every later access, read or write, reaches the high byte until the next control word for that channel. Reads and writes share this sequencing.
- R5: A write of the high byte completes the reload value and loads it into the counter. A write of the low byte alone only changes the reload value, which is used at the next reload.
- R6: A running channel decrements once for each cycle in which `tick_en` is high. When it steps from 1 it reloads the reload value and produces terminal count, so a reload value of N gives one terminal count every N ticks.
- R7: A completed reload value of zero stops the channel: its count stays at zero and it produces no terminal count.
- R8: After reset the counters read zero and are stopped, `irq` and `bcd_err` are low, and every access field is 00.
- R9: Each terminal count of channel 0 adds one to the pending count, and `irq` is high exactly while that count is above zero. Channels 1 and 2 never affect `irq`.
- R10: Each cycle with `irq_ack` high removes one pending event. An acknowledge at zero is ignored, and a terminal count together with an acknowledge in the same cycle leaves the count unchanged. The count saturates at 15 (2^PEND_W-1) instead of wrapping.
- R11: A control word with bit 0 set raises `bcd_err` and leaves every channel's access field and byte sequencing unchanged, although it is still returned by a control read. The next control word with bit 0 clear lowers `bcd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Timebase enable, one count step per high cycle |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address during a read |
| irq_ack | input | 1 | Retires one pending channel-0 event per high cycle |
| irq | output | 1 | High while channel-0 events are pending |
| bcd_err | output | 1 | High after an unsupported decimal-mode control word |

## Verification
A byte-sequencing flag left in the wrong state shows at the next count access to that channel. The access returns or writes the other half of the counter, and the mismatch appears in the same cycle the read is made. A counter or reload value that is off shows as terminal count arriving in the wrong cycle. In turn `irq` rises early or late by the size of the error, visible the cycle after the tick that should have ended the period. A pending count that wraps or underflows shows up once the acknowledge sequence ends: `irq` stays high after the acknowledge that should have lowered it, or drops before that acknowledge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NCH    = 3;
  localparam int AW     = 2;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] opmode;
    logic       bcd;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h04;
  localparam logic [AW-1:0]     CTRL_ADR = 2'd3;
endpackage

// File: rtl/ivt_regif.sv
module ivt_regif
  import ivt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [AW-1:0]               bus_addr,
  input  logic [BYTE_W-1:0]           bus_wdata,
  input  logic [NCH-1:0][CNT_W-1:0]   cnt_i,
  output logic [NCH-1:0]              ld_lo,
  output logic [NCH-1:0]              ld_hi,
  output logic [BYTE_W-1:0]           rdata,
  output logic [BYTE_W-1:0]           ctrl_o,
  output logic                        bcd_err
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              err_q, err_d;
  acc_e              acc_q [NCH];
  acc_e              acc_d [NCH];
  logic [NCH-1:0]    hi_q, hi_d;

  ctrl_t             cw;
  logic [1:0]        tgt;
  logic              ctrl_wr;
  logic [NCH-1:0]    hit, sel_lo, sel_hi;
  logic [BYTE_W-1:0] rd_byte [NCH];

  assign cw      = ctrl_t'(bus_wdata);
  assign tgt     = (cw.chan == 2'd3) ? 2'd0 : cw.chan;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == CTRL_ADR);

  // byte selection per channel
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]    = bus_sel && (bus_addr == AW'(i));
      sel_lo[i] = (acc_q[i] == ACC_LO)   || ((acc_q[i] == ACC_LOHI) && !hi_q[i]);
      sel_hi[i] = (acc_q[i] == ACC_HI)   || ((acc_q[i] == ACC_LOHI) &&  hi_q[i]);
      ld_lo[i]  = hit[i] && bus_wr && sel_lo[i];
      ld_hi[i]  = hit[i] && bus_wr && sel_hi[i];
      if (sel_hi[i])
        rd_byte[i] = cnt_i[i][CNT_W-1:BYTE_W];
      else if (sel_lo[i])
        rd_byte[i] = cnt_i[i][BYTE_W-1:0];
      else
        rd_byte[i] = '0;
    end
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    err_d  = err_q;
    hi_d   = hi_q;
    for (int i = 0; i < NCH; i++) acc_d[i] = acc_q[i];
    if (ctrl_wr) begin
      ctrl_d = bus_wdata;
      err_d  = cw.bcd;
    end
    for (int i = 0; i < NCH; i++) begin
      if (ctrl_wr && !cw.bcd && (tgt == 2'(i))) begin
        acc_d[i] = cw.acc;
        hi_d[i]  = 1'b0;
      end else if (hit[i] && (acc_q[i] == ACC_LOHI)) begin
        hi_d[i]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
      hi_q   <= '0;
      for (int i = 0; i < NCH; i++) acc_q[i] <= ACC_NONE;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
      hi_q   <= hi_d;
      for (int i = 0; i < NCH; i++) acc_q[i] <= acc_d[i];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == CTRL_ADR) begin
        rdata = ctrl_q;
      end else begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == AW'(i)) rdata = rd_byte[i];
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign bcd_err = err_q;
endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             run_q, run_d;
  logic             at_one;

  assign at_one = (cnt_q == CNT_W'(1));
  assign tc_o   = run_q && tick_en && at_one && !ld_hi;

  always_comb begin
    rld_d = rld_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (ld_lo) rld_d[BYTE_W-1:0]     = wbyte;
    if (ld_hi) rld_d[CNT_W-1:BYTE_W] = wbyte;
    if (ld_hi) begin
      cnt_d = rld_d;
      run_d = (rld_d != '0);
    end else if (run_q && tick_en) begin
      cnt_d = at_one ? rld_q : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/ivt_pend.sv
module ivt_pend #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt_o,
  output logic              irq_o
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc && !dec && (cnt_q != PMAX)) begin
      cnt_d  = cnt_q + PEND_W'(1);
      cnt_en = 1'b1;
    end else if (dec && !inc && (cnt_q != '0)) begin
      cnt_d  = cnt_q - PEND_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign irq_o = (cnt_q != '0);
endmodule

// File: rtl/ivt_timer3.sv
module ivt_timer3
  import ivt_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq,
  output logic              bcd_err
);
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [NCH-1:0][CNT_W-1:0] rld_w;
  logic [NCH-1:0]            tc_w, ld_lo_w, ld_hi_w;
  logic [BYTE_W-1:0]         ctrl_w;
  logic [PEND_W-1:0]         pend_w;

  ivt_regif u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_i(cnt_w), .ld_lo(ld_lo_w), .ld_hi(ld_hi_w),
    .rdata(bus_rdata), .ctrl_o(ctrl_w), .bcd_err(bcd_err)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ivt_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ld_lo(ld_lo_w[g]), .ld_hi(ld_hi_w[g]), .wbyte(bus_wdata),
      .cnt_o(cnt_w[g]), .rld_o(rld_w[g]), .tc_o(tc_w[g])
    );
  end

  ivt_pend #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(tc_w[0]), .dec(irq_ack),
    .cnt_o(pend_w), .irq_o(irq)
  );
endmodule

// File: rtl/ivt_timer3_chk.sv
module ivt_timer3_chk #(
  parameter int PEND_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              irq_ack,
  input logic              irq,
  input logic              bcd_err,
  input logic [7:0]        ctrl_q,
  input logic [2:0]        tc,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  rld0,
  input logic [PEND_W-1:0] pend
);
  logic ctrl_wr, cnt0_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == 2'd3);
  assign cnt0_wr = bus_sel && bus_wr && (bus_addr == 2'd0);

  p_ctrl_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(bus_wdata)));

  p_tc_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc[0] && !cnt0_wr) |=> (cnt0 == $past(rld0)));

  p_zero_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '0) |-> !tc[0]);

  p_tc_raises_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc[0] |=> irq);

  p_quiet_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !tc[0]) |=> !irq);

  p_last_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == PEND_W'(1)) && irq_ack && !tc[0]) |=> !irq);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((&pend) && !irq_ack) |=> (&pend));

  p_bcd_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[0]) |=> bcd_err);
endmodule

bind ivt_timer3 ivt_timer3_chk #(.PEND_W(PEND_W), .CNT_W(ivt_pkg::CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_ack(irq_ack),
  .irq(irq), .bcd_err(bcd_err), .ctrl_q(ctrl_w), .tc(tc_w),
  .cnt0(cnt_w[0]), .rld0(rld_w[0]), .pend(pend_w)
);

// File: tb/ivt_timer3_tb_top.sv
module ivt_timer3_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       bcd_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ivt_timer3 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq), .bcd_err(bcd_err)
  );

  // op: 0 write, 1 read+compare, 2 ticks (count in data), 3 irq compare
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd3, 8'h34, 8'h00, 4'd4},  // R4 ch0 low-then-high
    '{2'd0, 2'd0, 8'h03, 8'h00, 4'd5},  // R5 low byte
    '{2'd0, 2'd0, 8'h00, 8'h00, 4'd5},  // R5 high byte loads 3
    '{2'd1, 2'd3, 8'h00, 8'h34, 4'd1},  // R1 control readback
    '{2'd3, 2'd0, 8'h00, 8'h00, 4'd9},  // R9 nothing pending
    '{2'd2, 2'd0, 8'd2,  8'h00, 4'd6},  // R6 two ticks
    '{2'd3, 2'd0, 8'h00, 8'h00, 4'd6},  // R6 not yet terminal
    '{2'd2, 2'd0, 8'd1,  8'h00, 4'd6},  // R6 third tick
    '{2'd3, 2'd0, 8'h00, 8'h01, 4'd9},  // R9 pending
    '{2'd0, 2'd3, 8'h34, 8'h00, 4'd4},  // R4 restart sequencing
    '{2'd1, 2'd0, 8'h00, 8'h03, 4'd4},  // R4 low first
    '{2'd1, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 then high
    '{2'd1, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 stays high
    '{2'd0, 2'd3, 8'h50, 8'h00, 4'd3},  // R3 ch1 low only
    '{2'd0, 2'd1, 8'h77, 8'h00, 4'd3},  // R3
    '{2'd1, 2'd1, 8'h00, 8'h00, 4'd5},  // R5 low alone does not load
    '{2'd0, 2'd3, 8'h60, 8'h00, 4'd3},  // R3 ch1 high only
    '{2'd0, 2'd1, 8'h01, 8'h00, 4'd5},  // R5 loads 0x0177
    '{2'd1, 2'd1, 8'h00, 8'h01, 4'd3},  // R3 high byte
    '{2'd0, 2'd3, 8'h50, 8'h00, 4'd3},  // R3
    '{2'd1, 2'd1, 8'h00, 8'h77, 4'd3},  // R3 low byte
    '{2'd1, 2'd1, 8'h00, 8'h77, 4'd3},  // R3 low stays
    '{2'd0, 2'd3, 8'hD0, 8'h00, 4'd2},  // R2 select 3 -> ch0 low only
    '{2'd1, 2'd0, 8'h00, 8'h03, 4'd2},  // R2
    '{2'd1, 2'd0, 8'h00, 8'h03, 4'd2},  // R2 not sequenced
    '{2'd1, 2'd3, 8'h00, 8'hD0, 4'd1},  // R1
    '{2'd0, 2'd3, 8'h61, 8'h00, 4'd11}, // R11 decimal request on ch1
    '{2'd1, 2'd1, 8'h00, 8'h77, 4'd11}, // R11 ch1 still low only
    '{2'd1, 2'd3, 8'h00, 8'h61, 4'd11}, // R11 readback kept
    '{2'd0, 2'd3, 8'h80, 8'h00, 4'd3},  // R3 ch2 access 00
    '{2'd0, 2'd2, 8'h55, 8'h00, 4'd3},  // R3 write ignored
    '{2'd1, 2'd2, 8'h00, 8'h00, 4'd3},  // R3 reads zero
    '{2'd3, 2'd0, 8'h00, 8'h01, 4'd9}   // R9 still pending
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic pulse(input int n, input bit tk, input bit ak);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = tk; irq_ack = ak;
    end
    @(negedge clk);
    tick_en = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic e);
    @(negedge clk);
    #2 check(req, {7'd0, irq}, {7'd0, e});
  endtask

  task automatic reset_chk();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    irq_chk("R8", 1'b0);
    check("R8", {7'd0, bcd_err}, 8'h00);
    rd_chk("R8", 2'd3, 8'h04);   // R1 reset control value
    rd_chk("R8", 2'd0, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_chk();

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: begin rd(VECS[i].addr, v); check(tag, v, VECS[i].exp); end
        2'd2: pulse(int'(VECS[i].data), 1'b1, 1'b0);
        default: irq_chk(tag, VECS[i].exp[0]);
      endcase
    end

    // R10 single acknowledge clears
    pulse(1, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);

    // R7 zero reload stops channel 0
    wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    pulse(10, 1'b1, 1'b0);
    irq_chk("R7", 1'b0);
    wr(2'd3, 8'h34);
    rd_chk("R7", 2'd0, 8'h00);
    rd_chk("R7", 2'd0, 8'h00);

    // R10 saturation with period 1
    wr(2'd3, 8'h34); wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    pulse(20, 1'b1, 1'b0);
    irq_chk("R9", 1'b1);
    pulse(14, 1'b0, 1'b1);
    irq_chk("R10", 1'b1);
    pulse(1, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);
    pulse(3, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);
    pulse(1, 1'b1, 1'b0);
    irq_chk("R10", 1'b1);
    pulse(1, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);
    // R10 simultaneous tick and acknowledge
    pulse(1, 1'b1, 1'b0);
    pulse(1, 1'b1, 1'b1);
    irq_chk("R10", 1'b1);
    pulse(1, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);

    // R6 channel 1 count value after six ticks from 0x0105
    wr(2'd3, 8'h74); wr(2'd1, 8'h05); wr(2'd1, 8'h01);
    pulse(6, 1'b1, 1'b0);
    wr(2'd3, 8'h74);
    rd_chk("R6", 2'd1, 8'hFF);
    rd_chk("R6", 2'd1, 8'h00);

    // stop channel 0, drain pending
    wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    pulse(15, 1'b0, 1'b1);
    irq_chk("R10", 1'b0);

    // R6 / R9 channel 2 reload 2, no effect on irq
    wr(2'd3, 8'hB4); wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    pulse(1, 1'b1, 1'b0);
    wr(2'd3, 8'hB4);
    rd_chk("R6", 2'd2, 8'h01);
    pulse(1, 1'b1, 1'b0);
    wr(2'd3, 8'hB4);
    rd_chk("R6", 2'd2, 8'h02);
    irq_chk("R9", 1'b0);

    // R11 error flag set and cleared
    wr(2'd3, 8'h35);
    @(negedge clk);
    check("R11", {7'd0, bcd_err}, 8'h01);
    wr(2'd3, 8'h34);
    @(negedge clk);
    check("R11", {7'd0, bcd_err}, 8'h00);

    // R8 reset in the middle of operation
    wr(2'd3, 8'h35);
    reset_chk();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule